// File: doc/BRIEF.md
# Register-Mapped GPIO Port

This block is a general-purpose I/O port with a small bank of word-wide registers on a plain synchronous bus. Software drives pins through an output latch, chooses which lines are driven through a direction register, and reads line levels back through a data register. The latch can be loaded whole. It can also be changed bit by bit through a set register and a clear register. In both of those, a 1 in the written word touches the matching latch bit, so no read-modify-write is needed.

Build-time parameters fix four things: the word width (8, 16, 32 or 64 lines), which polarity of the direction register means "output", whether line numbering runs from the top bit of the register down, and whether the bytes of each bus word are swapped. The pins leave the block as a level vector and a drive-enable vector, for a tri-state pad ring. Incoming pin levels pass through a two-stage synchroniser before they can be read.

Word addresses: 0 data, 1 set, 2 clear, 3 direction. All other addresses are unmapped.

Top module: `mmio_gpio`

## Requirements
- R1: Reset (synchronous, active high) clears the output latch, makes every line an input so that every bit of `pins_oe` is 0, and clears `rd_data`.
- R2: A write to address 0 loads the whole output latch, and `pins_out` shows the new value after the clock edge that takes the write.
- R3: A write to address 1 sets every latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R4: A write to address 2 clears every latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R5: With `DIR_IS_INPUT`=0, a 1 in direction bit n makes line n an output. With `DIR_IS_INPUT`=1, a 1 in direction bit n makes line n an input. Reading address 3 returns the value last written there. After reset it reads all zeros in the first mode and all ones in the second.
- R6: Reading address 0 returns, for each output line, the latch bit. For each input line it returns the pin level seen through a two-flop synchroniser.
- R7: Reading address 1 returns the output latch whatever the pin levels are.
- R8: `rd_data` is registered and shows the selected register one cycle after `rd_en` is sampled. Reading address 2 or any unmapped address returns zero, and a write to an unmapped address changes nothing.
- R9: With `BIT_REV`=1, line n is carried on register bit W-1-n in every register.
- R10: With `BYTE_SWAP`=1, byte k of the bus word maps to byte W/8-1-k of the register, applied before bit reversal. This is legal only for W of 16 or 32; any other width, and any width outside {8,16,32,64}, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| addr | input | ADDR_W | Word address |
| wr_data | input | W | Write word |
| rd_data | output | W | Registered read word |
| pins_in | input | W | Asynchronous pin levels |
| pins_out | output | W | Output latch, one bit per line |
| pins_oe | output | W | Drive enable, 1 = line driven |

## Verification
The assertions assume one bus access per cycle: a cycle carries a write to one address or a read, never a set and a clear together. Under that assumption, a set-register write can only raise latch bits and a clear-register write can only lower them. They also assume `pins_in` may change in any cycle, so no property depends on pin timing. The bench drives all bus signals on the falling edge and makes single-access transactions. It waits three cycles after changing pins before reading them.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    REG_LEVEL = 2'd0,
    REG_SET   = 2'd1,
    REG_CLEAR = 2'd2,
    REG_DIR   = 2'd3
  } gpio_reg_e;

  localparam int SYNC_STAGES = 2;

  // register bit index -> bus bit index under byte swapping
  function automatic int swap_index(input int reg_bit, input int width, input bit do_swap);
    int nbytes;
    nbytes = width / 8;
    if (do_swap) return (nbytes - 1 - reg_bit / 8) * 8 + reg_bit % 8;
    return reg_bit;
  endfunction

endpackage

// File: rtl/gpio_lane_map.sv
// Static permutation between the bus word and the line vector.
module gpio_lane_map #(
  parameter int W         = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0,
  parameter bit TO_LINES  = 1'b1
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  import gpio_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int REG_BIT = BIT_REV ? (W - 1 - i) : i;
    localparam int BUS_BIT = swap_index(REG_BIT, W, BYTE_SWAP);
    if (TO_LINES) begin : g_in
      assign dst[i] = src[BUS_BIT];
    end else begin : g_out
      assign dst[BUS_BIT] = src[i];
    end
  end

endmodule

// File: rtl/gpio_sync.sv
// Multi-flop synchroniser for asynchronous pin levels.
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
// Output latch and drive-enable state, held in line order.
module gpio_ctrl_regs #(
  parameter int W            = 32,
  parameter bit DIR_IS_INPUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_level,
  input  logic         wr_set,
  input  logic         wr_clear,
  input  logic         wr_dir,
  input  logic [W-1:0] wr_lines,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] oe_q
);
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  always_comb begin
    set_mask = wr_set   ? wr_lines : '0;
    clr_mask = wr_clear ? wr_lines : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      oe_q    <= '0;
    end else begin
      if (wr_level)
        latch_q <= wr_lines;
      else if (wr_set || wr_clear)
        latch_q <= (latch_q & ~clr_mask) | set_mask;   // set wins on overlap
      if (wr_dir)
        oe_q <= DIR_IS_INPUT ? ~wr_lines : wr_lines;
    end
  end

endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
  import gpio_pkg::*;
#(
  parameter int W            = 32,
  parameter int ADDR_W       = 3,
  parameter bit DIR_IS_INPUT = 1'b0,
  parameter bit BIT_REV      = 1'b0,
  parameter bit BYTE_SWAP    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pins_in,
  output logic [W-1:0]      pins_out,
  output logic [W-1:0]      pins_oe
);
  localparam bit WIDTH_OK = (W == 8) || (W == 16) || (W == 32) || (W == 64);
  localparam bit SWAP_OK  = !BYTE_SWAP || (W == 16) || (W == 32);

  if (!WIDTH_OK) begin : g_bad_width
    $error("mmio_gpio: W must be 8, 16, 32 or 64");
  end
  if (!SWAP_OK) begin : g_bad_swap
    $error("mmio_gpio: byte swapping needs W of 16 or 32");
  end
  if (ADDR_W < 2) begin : g_bad_addr
    $error("mmio_gpio: ADDR_W must be at least 2");
  end

  // address decode
  logic      in_window;
  gpio_reg_e reg_sel;
  always_comb begin
    in_window = (addr >> 2) == '0;
    reg_sel   = gpio_reg_e'(addr[1:0]);
  end

  logic wr_level, wr_set, wr_clear, wr_dir;
  always_comb begin
    wr_level = wr_en && in_window && (reg_sel == REG_LEVEL);
    wr_set   = wr_en && in_window && (reg_sel == REG_SET);
    wr_clear = wr_en && in_window && (reg_sel == REG_CLEAR);
    wr_dir   = wr_en && in_window && (reg_sel == REG_DIR);
  end

  logic [W-1:0] wr_lines;
  gpio_lane_map #(.W(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP), .TO_LINES(1'b1)) u_wr_map (
    .src (wr_data),
    .dst (wr_lines)
  );

  logic [W-1:0] latch_q, oe_q;
  gpio_ctrl_regs #(.W(W), .DIR_IS_INPUT(DIR_IS_INPUT)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_level (wr_level),
    .wr_set   (wr_set),
    .wr_clear (wr_clear),
    .wr_dir   (wr_dir),
    .wr_lines (wr_lines),
    .latch_q  (latch_q),
    .oe_q     (oe_q)
  );

  logic [W-1:0] pins_sync;
  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pins_in),
    .sync_out (pins_sync)
  );

  // read selection in line order, mapped to the bus afterwards
  logic [W-1:0] rd_lines;
  always_comb begin
    rd_lines = '0;
    if (in_window) begin
      unique case (reg_sel)
        REG_LEVEL: rd_lines = (oe_q & latch_q) | (~oe_q & pins_sync);
        REG_SET:   rd_lines = latch_q;
        REG_CLEAR: rd_lines = '0;
        REG_DIR:   rd_lines = DIR_IS_INPUT ? ~oe_q : oe_q;
        default:   rd_lines = '0;
      endcase
    end
  end

  logic [W-1:0] rd_word;
  gpio_lane_map #(.W(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP), .TO_LINES(1'b0)) u_rd_map (
    .src (rd_lines),
    .dst (rd_word)
  );

  logic [W-1:0] rd_q;
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_word;
    else            rd_q <= '0;
  end

  assign rd_data  = rd_q;
  assign pins_out = latch_q;
  assign pins_oe  = oe_q;

endmodule

// File: rtl/mmio_gpio_checker.sv
module mmio_gpio_checker #(
  parameter int W      = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      rd_data,
  input logic [W-1:0]      pins_out,
  input logic [W-1:0]      pins_oe
);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(3);

  logic latch_write;
  always_comb latch_write = wr_en && (addr == A_LEVEL || addr == A_SET || addr == A_CLEAR);

  // R1: first cycle out of reset shows a cleared latch and no drive
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pins_out == '0 && pins_oe == '0));

  // R3: a set-register write can only raise latch bits
  a_r3_set_only_raises: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SET) |=> ((pins_out & $past(pins_out)) == $past(pins_out)));

  // R4: a clear-register write can only lower latch bits
  a_r4_clear_only_lowers: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLEAR) |=> ((pins_out & ~$past(pins_out)) == '0));

  // R2 / R8: latch moves only on a latch-register write
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !latch_write |=> $stable(pins_out));

  // R5 / R8: drive enables move only on a direction write
  a_r5_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_DIR) |=> $stable(pins_oe));

  // R8: clear register and unmapped addresses read as zero
  a_r8_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == A_CLEAR || addr > A_DIR)) |=> (rd_data == '0));

  // R8: no read strobe, no read data
  a_r8_idle_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

endmodule

bind mmio_gpio mmio_gpio_checker #(.W(W), .ADDR_W(ADDR_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .rd_data  (rd_data),
  .pins_out (pins_out),
  .pins_oe  (pins_oe)
);

// File: tb/test_mmio_gpio.sv
`timescale 1ns/1ps
module test_mmio_gpio;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // DUT A: 32 lines, output-polarity direction, natural ordering
  logic        a_wr = 0, a_rd = 0;
  logic [2:0]  a_addr = '0;
  logic [31:0] a_wdata = '0, a_rdata, a_pins_in = 32'hA5A5_0F0F, a_pins_out, a_oe;

  mmio_gpio #(.W(32), .ADDR_W(3)) i_mmio_gpio (
    .clk(clk), .rst(rst), .wr_en(a_wr), .rd_en(a_rd), .addr(a_addr),
    .wr_data(a_wdata), .rd_data(a_rdata), .pins_in(a_pins_in),
    .pins_out(a_pins_out), .pins_oe(a_oe)
  );

  // DUT B: 16 lines, input-polarity direction, reversed bits, swapped bytes
  logic        b_wr = 0, b_rd = 0;
  logic [2:0]  b_addr = '0;
  logic [15:0] b_wdata = '0, b_rdata, b_pins_in = '0, b_pins_out, b_oe;

  mmio_gpio #(.W(16), .ADDR_W(3), .DIR_IS_INPUT(1'b1), .BIT_REV(1'b1), .BYTE_SWAP(1'b1)) i_mmio_gpio_alt (
    .clk(clk), .rst(rst), .wr_en(b_wr), .rd_en(b_rd), .addr(b_addr),
    .wr_data(b_wdata), .rd_data(b_rdata), .pins_in(b_pins_in),
    .pins_out(b_pins_out), .pins_oe(b_oe)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic a_write(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk); a_addr = ad; a_wdata = d; a_wr = 1'b1;
    @(negedge clk); a_wr = 1'b0;
  endtask

  task automatic a_read(input logic [2:0] ad, output logic [31:0] d);
    @(negedge clk); a_addr = ad; a_rd = 1'b1;
    @(negedge clk); a_rd = 1'b0; d = a_rdata;
  endtask

  task automatic b_write(input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk); b_addr = ad; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic b_read(input logic [2:0] ad, output logic [15:0] d);
    @(negedge clk); b_addr = ad; b_rd = 1'b1;
    @(negedge clk); b_rd = 1'b0; d = b_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // row: [35] 1 = read and compare, [34:32] address, [31:0] write data or expected
  localparam logic [35:0] VEC [12] = '{
    {1'b0, 3'd3, 32'h0000_FFFF},   // low half outputs
    {1'b0, 3'd0, 32'h1234_5678},
    {1'b1, 3'd0, 32'hA5A5_5678},   // R6 mixed read
    {1'b0, 3'd1, 32'hFFFF_0001},
    {1'b1, 3'd1, 32'hFFFF_5679},   // R3 / R7
    {1'b0, 3'd2, 32'h0F00_0078},
    {1'b1, 3'd1, 32'hF0FF_5601},   // R4 / R7
    {1'b1, 3'd0, 32'hA5A5_5601},   // R6
    {1'b1, 3'd2, 32'h0000_0000},   // R8 clear reads zero
    {1'b1, 3'd5, 32'h0000_0000},   // R8 unmapped
    {1'b1, 3'd3, 32'h0000_FFFF},   // R5 readback
    {1'b0, 3'd7, 32'hFFFF_FFFF}    // R8 unmapped write
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ra;
    logic [15:0] rb;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", "A latch", a_pins_out, 0);
    check("R1", "A oe", a_oe, 0);
    check("R1", "A rd_data", a_rdata, 0);
    check("R1", "B oe", b_oe, 0);
    a_read(3'd0, ra); check("R6", "A all inputs read pins", ra, 32'hA5A5_0F0F);
    a_read(3'd3, ra); check("R5", "A dir after reset", ra, 0);
    b_read(3'd3, rb); check("R5", "B dir after reset", rb, 16'hFFFF);

    // table walk
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][35]) begin
        a_read(VEC[i][34:32], ra);
        case (VEC[i][34:32])
          3'd0:    check("R6", $sformatf("row %0d level read", i), ra, VEC[i][31:0]);
          3'd1:    check("R7", $sformatf("row %0d set read", i), ra, VEC[i][31:0]);
          3'd3:    check("R5", $sformatf("row %0d dir read", i), ra, VEC[i][31:0]);
          default: check("R8", $sformatf("row %0d zero read", i), ra, VEC[i][31:0]);
        endcase
      end else begin
        a_write(VEC[i][34:32], VEC[i][31:0]);
      end
    end

    check("R8", "unmapped write left latch", a_pins_out, 32'hF0FF_5601);
    check("R5", "A oe from dir", a_oe, 32'h0000_FFFF);

    // R6 pin change through the synchroniser
    a_pins_in = 32'h3C3C_0000;
    repeat (3) @(negedge clk);
    a_read(3'd0, ra); check("R6", "new pins", ra, 32'h3C3C_5601);

    // R2 whole-word load
    a_write(3'd0, 32'h0000_0000);
    check("R2", "latch load zero", a_pins_out, 0);
    a_write(3'd0, 32'hDEAD_BEEF);
    check("R2", "latch load word", a_pins_out, 32'hDEAD_BEEF);

    // B: swapped bytes and reversed bits
    b_write(3'd0, 16'h0001);
    check("R10", "B byte swap write", b_pins_out, 16'h0080);
    b_write(3'd3, 16'h00FE);
    check("R5", "B input polarity oe", b_oe, 16'hFF80);
    b_read(3'd3, rb); check("R5", "B dir readback", rb, 16'h00FE);
    b_write(3'd1, 16'h8000);
    check("R9", "B reversed set", b_pins_out, 16'h0180);
    b_pins_in = 16'h0001;
    repeat (3) @(negedge clk);
    b_read(3'd0, rb); check("R9", "B mixed level read", rb, 16'h8081);
    b_write(3'd2, 16'h0001);
    check("R4", "B reversed clear", b_pins_out, 16'h0100);

    // R1 reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "A latch after reset", a_pins_out, 0);
    check("R1", "A oe after reset", a_oe, 0);
    check("R1", "B latch after reset", b_pins_out, 0);
    rst = 1'b0;
    @(negedge clk);
    b_read(3'd3, rb); check("R5", "B dir after second reset", rb, 16'hFFFF);

    finish_run();
  end

endmodule